// File: doc/BRIEF.md
# Keypad Scan Encoder with Two-Key Rollover

This block reads a matrix of single-pole push switches. It pulls one column low at a time and samples the row lines. Each row line is treated as pulled high, so an open switch reads 1. When a closed switch appears in the active column, the block checks that the closure stays put for a programmable number of scan ticks. It then latches the position as a binary key code and raises a data-available flag. Scanning is paced by a one-cycle scan-enable tick. The tick can come from a divided system clock or from any external timing source.

Only one key is held as accepted at a time. While it is held, scanning stays on its column so that its release can be seen. The flag drops as soon as the accepted key opens, even if another key is still down. That other key is then found by the resumed scan and must pass a full fresh debounce before the flag rises again. This gives two-key rollover between any pair of switches, and no diode isolation is needed in the matrix. Row inputs pass through a synchronizer before use.

Top module: `keypad_scan_encoder`

## Requirements
- R1: Synchronous reset clears key_avail to 0 and key_code to 0, and drives col_n to 4'b1110 (column 0 active).
- R2: Exactly one col_n bit is low. With no key closed, each scan tick moves the low bit to the next column (bit c to bit c+1), wrapping from column 3 to column 0. Without a tick the column does not move.
- R3: A key is detected on the tick at which its column is active and its row reads 0. It is accepted DEBOUNCE_TICKS ticks later if it reads closed on every one of those ticks. From reset, a lone key in column c raises key_avail on tick c+1+DEBOUNCE_TICKS.
- R4: If the candidate key reads open on any debounce tick, the candidate is dropped with key_avail low, and the next detection starts the count again from zero.
- R5: The key code is row*4 + column (row index = row_n bit, column index = col_n bit). It stays unchanged while key_avail is high and after release until another key is accepted.
- R6: key_avail falls on the first tick at which the accepted key reads open, whether or not another key is held.
- R7: After a release, scanning resumes at the released key's column one tick later. Another held key is then accepted only after a full debounce period.
- R8: If several rows read closed in the active column, only the lowest-numbered row is taken as the candidate.
- R9: col_n does not change while key_avail is high.
- R10: If the released key closes again before scanning resumes, key_avail stays low until the key has read open on a tick and has been debounced anew.
- R11: With DEBOUNCE_TICKS = 0, a key is accepted on its detection tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_tick | input | 1 | One-cycle pulse that advances the scan and debounce |
| row_n | input | ROWS | Row sense lines, 0 = switch closed to the active column |
| col_n | output | COLS | Column drives, active low, one low at a time |
| key_code | output | $clog2(ROWS*COLS) | Latched code of the accepted key |
| key_avail | output | 1 | High while a debounced key is accepted and held |

## Verification
Two functions can land on the same tick. The first is the release of the accepted key, which drops the flag. The second is the scan's view of a second key that is already closed, which in the same-column case is re-detected only one tick later. The bench holds the second key across the release in both arrangements, same column and different column. It judges the exact tick count until the flag returns against the resume-plus-debounce formula, and checks that the code stays at the first key until then. A bounce during debounce and a re-closure in the wait-release state are also forced on a known tick. The resulting extra delay is compared with a fresh full debounce.

// File: rtl/kp_pkg.sv
package kp_pkg;
    typedef enum logic [1:0] {
        ST_SCAN     = 2'd0,
        ST_DEBOUNCE = 2'd1,
        ST_VALID    = 2'd2,
        ST_WAIT_REL = 2'd3
    } kp_state_e;
endpackage

// File: rtl/kp_row_sync.sv
module kp_row_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '1;
                else     stage_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '1;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/kp_col_drive.sv
module kp_col_drive #(
    parameter int COLS  = 4,
    parameter int COL_W = 2
) (
    input  logic [COL_W-1:0] col_idx,
    output logic [COLS-1:0]  col_n
);
    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign col_n[c] = (col_idx != COL_W'(c));
    end
endmodule

// File: rtl/kp_row_pick.sv
module kp_row_pick #(
    parameter int ROWS  = 4,
    parameter int ROW_W = 2
) (
    input  logic [ROWS-1:0]  rows_n,
    output logic             hit,
    output logic [ROW_W-1:0] row_idx
);
    always_comb begin
        hit     = 1'b0;
        row_idx = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (!rows_n[r]) begin
                hit     = 1'b1;
                row_idx = ROW_W'(r);
            end
        end
    end
endmodule

// File: rtl/keypad_scan_encoder.sv
module keypad_scan_encoder
    import kp_pkg::*;
#(
    parameter int ROWS           = 4,
    parameter int COLS           = 4,
    parameter int DEBOUNCE_TICKS = 3,
    parameter int SYNC_STAGES    = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          scan_tick,
    input  logic [ROWS-1:0]               row_n,
    output logic [COLS-1:0]               col_n,
    output logic [$clog2(ROWS*COLS)-1:0]  key_code,
    output logic                          key_avail
);
    localparam int CODE_W = $clog2(ROWS * COLS);
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int CNT_W  = (DEBOUNCE_TICKS > 0) ? $clog2(DEBOUNCE_TICKS + 1) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST =
        (DEBOUNCE_TICKS > 0) ? CNT_W'(DEBOUNCE_TICKS - 1) : '0;

    typedef struct packed {
        kp_state_e          state;
        logic [COL_W-1:0]   col;
        logic [ROW_W-1:0]   row;
        logic [CNT_W-1:0]   cnt;
        logic [CODE_W-1:0]  code;
        logic               avail;
    } scan_regs_t;

    localparam scan_regs_t REGS_RESET = '{
        state: ST_SCAN, col: '0, row: '0, cnt: '0, code: '0, avail: 1'b0
    };

    scan_regs_t         regs_d, regs_q;
    logic [ROWS-1:0]    rows_s;
    logic               row_hit;
    logic [ROW_W-1:0]   row_pick;
    logic               cand_open;
    logic [CODE_W-1:0]  code_here;

    kp_row_sync #(.W(ROWS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (row_n),
        .q   (rows_s)
    );

    kp_row_pick #(.ROWS(ROWS), .ROW_W(ROW_W)) u_pick (
        .rows_n  (rows_s),
        .hit     (row_hit),
        .row_idx (row_pick)
    );

    kp_col_drive #(.COLS(COLS), .COL_W(COL_W)) u_cols (
        .col_idx (regs_q.col),
        .col_n   (col_n)
    );

    assign cand_open = rows_s[regs_q.row];

    always_comb begin
        code_here = CODE_W'(int'(row_pick) * COLS + int'(regs_q.col));
        if (regs_q.state != ST_SCAN)
            code_here = CODE_W'(int'(regs_q.row) * COLS + int'(regs_q.col));
    end

    always_comb begin
        regs_d = regs_q;
        if (scan_tick) begin
            unique case (regs_q.state)
                ST_SCAN: begin
                    if (row_hit) begin
                        regs_d.row = row_pick;
                        regs_d.cnt = '0;
                        if (DEBOUNCE_TICKS == 0) begin
                            regs_d.code  = code_here;
                            regs_d.avail = 1'b1;
                            regs_d.state = ST_VALID;
                        end else begin
                            regs_d.state = ST_DEBOUNCE;
                        end
                    end else if (regs_q.col == COL_W'(COLS - 1)) begin
                        regs_d.col = '0;
                    end else begin
                        regs_d.col = regs_q.col + 1'b1;
                    end
                end
                ST_DEBOUNCE: begin
                    if (cand_open) begin
                        regs_d.cnt   = '0;
                        regs_d.state = ST_SCAN;
                    end else if (regs_q.cnt == CNT_LAST) begin
                        regs_d.code  = code_here;
                        regs_d.avail = 1'b1;
                        regs_d.state = ST_VALID;
                    end else begin
                        regs_d.cnt = regs_q.cnt + 1'b1;
                    end
                end
                ST_VALID: begin
                    if (cand_open) begin
                        regs_d.avail = 1'b0;
                        regs_d.state = ST_WAIT_REL;
                    end
                end
                ST_WAIT_REL: begin
                    if (cand_open) regs_d.state = ST_SCAN;
                end
                default: regs_d = REGS_RESET;
            endcase
        end
        if (rst) regs_d = REGS_RESET;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign key_code  = regs_q.code;
    assign key_avail = regs_q.avail;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!key_avail && key_code == '0));

    // R2
    one_col_low_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~col_n) == 1);

    // R2
    col_hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !scan_tick |=> $stable(col_n));

    // R3
    avail_rise_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(key_avail) |-> $past(scan_tick));

    // R5
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (key_avail && $past(key_avail)) |-> $stable(key_code));

    // R9
    col_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (key_avail && $past(key_avail)) |-> $stable(col_n));
endmodule

// File: tb/tb_keypad_scan_encoder.sv
module tb_keypad_scan_encoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scan_tick = 1'b0;
    logic [15:0] pressed_a = '0;
    logic [15:0] pressed_b = '0;
    logic [3:0]  row_a, row_b, col_a, col_b, code_a, code_b;
    logic        avail_a, avail_b;
    int          n_checks = 0;
    int          n_fails  = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [3:0] matrix(input logic [15:0] p, input logic [3:0] cn);
        logic [3:0] res = 4'hF;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                if (p[r*4+c] && !cn[c]) res[r] = 1'b0;
        return res;
    endfunction

    assign row_a = matrix(pressed_a, col_a);
    assign row_b = matrix(pressed_b, col_b);

    keypad_scan_encoder #(.DEBOUNCE_TICKS(3)) dut (
        .clk(clk), .rst(rst), .scan_tick(scan_tick), .row_n(row_a),
        .col_n(col_a), .key_code(code_a), .key_avail(avail_a));

    keypad_scan_encoder #(.DEBOUNCE_TICKS(0)) dut_nodb (
        .clk(clk), .rst(rst), .scan_tick(scan_tick), .row_n(row_b),
        .col_n(col_b), .key_code(code_b), .key_avail(avail_b));

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk) scan_tick = 1'b1;
        @(negedge clk) scan_tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic key(input int r, input int c, input bit down);
        @(negedge clk) pressed_a[r*4+c] = down;
        settle();
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        pressed_a = '0;
        pressed_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        settle();
    endtask

    task automatic ticks_until_avail(output int n);
        n = 0;
        while (!avail_a && n < 20) begin
            tick();
            n++;
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 col_n after reset", col_a, 4'b1110);
        check("R1 avail after reset", avail_a, 0);
        check("R1 code after reset", code_a, 0);
    endtask

    task automatic t_scan();
        do_reset();
        tick(); check("R2 col 1", col_a, 4'b1101);
        tick(); check("R2 col 2", col_a, 4'b1011);
        tick(); check("R2 col 3", col_a, 4'b0111);
        tick(); check("R2 wrap to col 0", col_a, 4'b1110);
        repeat (10) @(negedge clk);
        check("R2 no tick no move", col_a, 4'b1110);
    endtask

    task automatic t_accept();
        int n;
        do_reset();
        key(2, 1, 1);
        ticks_until_avail(n);
        check("R3 ticks to accept r2c1", n, 5);
        check("R5 code r2c1", code_a, 9);
        repeat (3) tick();
        check("R9 column frozen", col_a, 4'b1101);
        check("R9 avail while held", avail_a, 1);
        key(2, 1, 0);
        tick();
        check("R6 avail drops on release", avail_a, 0);
        check("R5 code kept after release", code_a, 9);
        key(1, 0, 1);
        check("R1 mid-run reset precondition", col_a, 4'b1101);
        do_reset();
        check("R1 mid-run reset col", col_a, 4'b1110);
        check("R1 mid-run reset code", code_a, 0);
    endtask

    task automatic t_same_column();
        int n;
        do_reset();
        key(1, 2, 1);
        key(3, 2, 1);
        ticks_until_avail(n);
        check("R8 ticks to accept", n, 6);
        check("R8 lowest row wins", code_a, 6);
        key(1, 2, 0);
        tick();
        check("R6 drop with r3c2 held", avail_a, 0);
        ticks_until_avail(n);
        check("R7 same column rollover ticks", n, 5);
        check("R7 same column rollover code", code_a, 14);
    endtask

    task automatic t_rollover();
        int n;
        do_reset();
        key(0, 1, 1);
        key(2, 3, 1);
        ticks_until_avail(n);
        check("R3 ticks to accept r0c1", n, 5);
        check("R5 code r0c1", code_a, 1);
        key(0, 1, 0);
        tick();
        check("R6 drop with r2c3 held", avail_a, 0);
        check("R5 code kept during rollover", code_a, 1);
        ticks_until_avail(n);
        check("R7 cross column rollover ticks", n, 7);
        check("R7 cross column rollover code", code_a, 11);
    endtask

    task automatic t_bounce();
        int n;
        do_reset();
        key(0, 0, 1);
        tick();
        tick();
        key(0, 0, 0);
        tick();
        check("R4 bounce cancels", avail_a, 0);
        key(0, 0, 1);
        ticks_until_avail(n);
        check("R4 count restarts from zero", n, 4);
        key(0, 0, 0);
        tick();
        check("R6 release r0c0", avail_a, 0);
        key(0, 0, 1);
        tick();
        tick();
        check("R10 reclose keeps avail low", avail_a, 0);
        key(0, 0, 0);
        tick();
        key(0, 0, 1);
        ticks_until_avail(n);
        check("R10 fresh debounce after reopen", n, 4);
    endtask

    task automatic t_no_debounce();
        do_reset();
        @(negedge clk) pressed_b[1*4+0] = 1'b1;
        settle();
        tick();
        check("R11 accept on detection tick", avail_b, 1);
        check("R11 code r1c0", code_b, 4);
    endtask

    initial begin
        t_reset();
        t_scan();
        t_accept();
        t_same_column();
        t_rollover();
        t_bounce();
        t_no_debounce();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule